// File: doc/BRIEF.md
# Two-Bank Frame Buffer Sequencer

This block runs in the memory clock domain and shares one memory port between image writes and image reads. The writes come from a camera-side FIFO and the reads refill a display-side FIFO. It polls two FIFO levels: how many words the write FIFO holds and how much room the read FIFO has. From these it issues whole bursts over a simple request/acknowledge command port. Each command carries a direction, a bank code and a word address within that bank. Only one burst is outstanding at a time.

Frames are double-buffered across two fixed, non-adjacent banks, codes 0 and 3. The camera-side frame-done pulse moves the writer to the other bank. The reader always works in the bank that most recently completed a frame. A display-side frame-done pulse restarts the read address. Frame events that arrive while a burst is outstanding are held and take effect only after that burst is acknowledged.

The clock-domain FIFOs, event synchronisers and low-level memory command timing sit outside this block. Its asynchronous active-low reset is expected to be released synchronously to the clock.

Top module: `fbs_seq`

## Requirements
- R1: After reset no request is raised, and the first write burst targets bank code 0 at address 0.
- R2: A write burst is requested only when the write FIFO level is at least BURST words. A level of BURST-1 raises no request.
- R3: A read burst is requested only when two conditions hold: at least one write frame has completed since reset, and the read FIFO has room for at least BURST words. Room of BURST-1 raises no request.
- R4: When a write and a read are both possible in the same cycle, the write is issued first.
- R5: After each acknowledged burst, the address of that direction advances by BURST. It wraps to 0 when it would reach FRAME_WORDS.
- R6: A write-side frame-done pulse toggles the write bank between code 0 (2'd0) and code 3 (2'd3), and restarts the write address at 0.
- R7: The read bank is always the bank that most recently completed a frame, which is never the bank being written. When it changes, the read address restarts at 0.
- R8: A frame-done pulse that arrives while a burst is outstanding changes nothing until that burst is acknowledged. The bank switch applies in the first idle cycle after that.
- R9: A read-side frame-done pulse restarts the read address at 0 and keeps the read bank unchanged.
- R10: While a request is waiting for acknowledge, the request, direction, bank and address stay unchanged. The request drops in the cycle after acknowledge, so bursts never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_fifo_level | input | LVL_W | Words held in the camera-side FIFO |
| rd_fifo_space | input | LVL_W | Free words in the display-side FIFO |
| wr_frame_done | input | 1 | One-cycle pulse: camera finished writing a frame |
| rd_frame_done | input | 1 | One-cycle pulse: display finished a frame |
| mem_req | output | 1 | Burst request, held until acknowledged |
| mem_we | output | 1 | 1 = write burst, 0 = read burst |
| mem_bank | output | 2 | Bank code, 0 or 3 |
| mem_addr | output | ADDR_W | Word address of the burst within the bank |
| mem_ack | input | 1 | One-cycle acknowledge of the current burst |

## Verification
A wrong bank register shows up on the first burst issued after a frame boundary. Either the write carries the old bank code, or the read carries the bank currently being written, and both are visible in the command fields within one idle cycle plus one issue cycle. A wrong address pointer appears on the next burst of the same direction, as an offset that is not the previous one plus BURST, or that is missing its wrap to zero. A broken arbitration or pending-event register shows up in two ways: as a command issued while the FIFO thresholds say it must not be, or as the wrong direction winning when both are possible. The scoreboard compares every issued command field-by-field against an order worked out from the requirements.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } fbs_state_e;

  localparam logic [1:0] BANK_LO = 2'd0;
  localparam logic [1:0] BANK_HI = 2'd3;

  function automatic logic [1:0] fbs_other_bank(input logic [1:0] b);
    return (b == BANK_LO) ? BANK_HI : BANK_LO;
  endfunction

endpackage

// File: rtl/fbs_ptr.sv
module fbs_ptr
  import fbs_pkg::*;
#(
  parameter int         BURST       = 256,
  parameter int         FRAME_WORDS = 393216,
  parameter int         ADDR_W      = $clog2(FRAME_WORDS),
  parameter logic [1:0] START_BANK  = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic              restart_en,
  input  logic              toggle_en,
  output logic [1:0]        bank,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W:0] STEP  = (ADDR_W+1)'(BURST);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(FRAME_WORDS);

  logic [1:0]        bank_n;
  logic [ADDR_W-1:0] addr_n;
  logic [ADDR_W:0]   sum;
  logic              upd_en;

  always_comb begin
    sum    = {1'b0, addr} + STEP;
    bank_n = toggle_en ? fbs_other_bank(bank) : bank;
    addr_n = addr;
    if (toggle_en || restart_en) begin
      addr_n = '0;
    end else if (adv_en) begin
      addr_n = (sum >= LIMIT) ? '0 : sum[ADDR_W-1:0];
    end
    upd_en = adv_en | restart_en | toggle_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank <= START_BANK;
      addr <= '0;
    end else if (upd_en) begin
      bank <= bank_n;
      addr <= addr_n;
    end
  end

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en && !restart_en && !toggle_en |=> (addr == '0) || ({1'b0, addr} == {1'b0, $past(addr)} + STEP));

endmodule

// File: rtl/fbs_arb.sv
module fbs_arb
  import fbs_pkg::*;
#(
  parameter int BURST = 256,
  parameter int LVL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] wr_fifo_level,
  input  logic [LVL_W-1:0] rd_fifo_space,
  input  logic             wr_frame_done,
  input  logic             rd_frame_done,
  input  logic             mem_ack,
  output logic             req,
  output logic             we,
  output logic             wr_adv,
  output logic             rd_adv,
  output logic             apply_wdone,
  output logic             apply_rdone
);

  localparam logic [LVL_W-1:0] BURST_L = LVL_W'(BURST);

  fbs_state_e state, state_n;
  logic       we_q, we_n;
  logic       wpend, wpend_n;
  logic       rpend, rpend_n;
  logic       rvalid, rvalid_n;
  logic       wr_ok, rd_ok;

  assign wr_ok = (wr_fifo_level >= BURST_L);
  assign rd_ok = rvalid && (rd_fifo_space >= BURST_L);

  always_comb begin
    state_n     = state;
    we_n        = we_q;
    wpend_n     = wpend | wr_frame_done;
    rpend_n     = rpend | rd_frame_done;
    rvalid_n    = rvalid;
    apply_wdone = 1'b0;
    apply_rdone = 1'b0;
    wr_adv      = 1'b0;
    rd_adv      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (wpend || rpend) begin
          apply_wdone = wpend;
          apply_rdone = rpend;
          wpend_n     = wr_frame_done;
          rpend_n     = rd_frame_done;
          if (wpend) rvalid_n = 1'b1;
        end else if (wr_ok) begin
          state_n = ST_BUSY;
          we_n    = 1'b1;
        end else if (rd_ok) begin
          state_n = ST_BUSY;
          we_n    = 1'b0;
        end
      end
      ST_BUSY: begin
        if (mem_ack) begin
          state_n = ST_IDLE;
          wr_adv  = we_q;
          rd_adv  = ~we_q;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      we_q   <= 1'b0;
      wpend  <= 1'b0;
      rpend  <= 1'b0;
      rvalid <= 1'b0;
    end else begin
      state  <= state_n;
      we_q   <= we_n;
      wpend  <= wpend_n;
      rpend  <= rpend_n;
      rvalid <= rvalid_n;
    end
  end

  assign req = (state == ST_BUSY);
  assign we  = we_q;

  // R8
  no_apply_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !apply_wdone && !apply_rdone);

  // R3
  read_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) && !we |-> rvalid);

endmodule

// File: rtl/fbs_seq.sv
module fbs_seq
  import fbs_pkg::*;
#(
  parameter int BURST       = 256,
  parameter int FRAME_WORDS = 393216,
  parameter int FIFO_DEPTH  = 1024,
  parameter int LVL_W       = $clog2(FIFO_DEPTH) + 1,
  parameter int ADDR_W      = $clog2(FRAME_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  wr_fifo_level,
  input  logic [LVL_W-1:0]  rd_fifo_space,
  input  logic              wr_frame_done,
  input  logic              rd_frame_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_bank,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack
);

  localparam int              NSIDE   = 2;
  localparam logic [LVL_W-1:0] BURST_L = LVL_W'(BURST);

  logic              wr_adv, rd_adv, apply_wdone, apply_rdone;
  logic [NSIDE-1:0]  adv, restart, toggle;
  logic [1:0]        bank [NSIDE];
  logic [ADDR_W-1:0] addr [NSIDE];

  fbs_arb #(
    .BURST (BURST),
    .LVL_W (LVL_W)
  ) arb_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_fifo_level (wr_fifo_level),
    .rd_fifo_space (rd_fifo_space),
    .wr_frame_done (wr_frame_done),
    .rd_frame_done (rd_frame_done),
    .mem_ack       (mem_ack),
    .req           (mem_req),
    .we            (mem_we),
    .wr_adv        (wr_adv),
    .rd_adv        (rd_adv),
    .apply_wdone   (apply_wdone),
    .apply_rdone   (apply_rdone)
  );

  // side 0 = write pointer, side 1 = read pointer
  assign adv     = {rd_adv, wr_adv};
  assign restart = {apply_rdone, 1'b0};
  assign toggle  = {apply_wdone, apply_wdone};

  for (genvar g = 0; g < NSIDE; g++) begin : g_ptr
    fbs_ptr #(
      .BURST       (BURST),
      .FRAME_WORDS (FRAME_WORDS),
      .ADDR_W      (ADDR_W),
      .START_BANK  ((g == 0) ? BANK_LO : BANK_HI)
    ) ptr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv_en     (adv[g]),
      .restart_en (restart[g]),
      .toggle_en  (toggle[g]),
      .bank       (bank[g]),
      .addr       (addr[g])
    );
  end

  assign mem_bank = mem_we ? bank[0] : bank[1];
  assign mem_addr = mem_we ? addr[0] : addr[1];

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_bank) && $stable(mem_addr));

  // R10
  drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req);

  // R6
  bank_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_bank == BANK_LO) || (mem_bank == BANK_HI));

  // R7
  read_other_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_bank != bank[0]);

  // R8
  bank_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(bank[0]) && $stable(bank[1]));

  // R2
  wr_threshold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) && mem_we |-> $past(wr_fifo_level) >= BURST_L);

endmodule

// File: tb/fbs_seq_tb.sv
module fbs_seq_tb_top;

  localparam int BURST  = 4;
  localparam int FRAME  = 16;
  localparam int DEPTH  = 16;
  localparam int LVL_W  = $clog2(DEPTH) + 1;
  localparam int ADDR_W = $clog2(FRAME);
  localparam int LAT    = 3;

  typedef struct {
    logic              we;
    logic [1:0]        bank;
    logic [ADDR_W-1:0] addr;
    string             tag;
  } cmd_t;

  logic              clk, rst_n;
  logic [LVL_W-1:0]  wr_fifo_level, rd_fifo_space;
  logic              wr_frame_done, rd_frame_done;
  logic              mem_req, mem_we, mem_ack;
  logic [1:0]        mem_bank;
  logic [ADDR_W-1:0] mem_addr;

  int   n_checks = 0;
  int   n_fail   = 0;
  int   ack_cnt  = 0;
  int   lat_cnt  = 0;
  logic prev_req = 1'b0;
  logic done     = 1'b0;
  cmd_t exp_q[$];

  fbs_seq #(
    .BURST       (BURST),
    .FRAME_WORDS (FRAME),
    .FIFO_DEPTH  (DEPTH)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_fifo_level (wr_fifo_level),
    .rd_fifo_space (rd_fifo_space),
    .wr_frame_done (wr_frame_done),
    .rd_frame_done (rd_frame_done),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_bank      (mem_bank),
    .mem_addr      (mem_addr),
    .mem_ack       (mem_ack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural memory: fixed acknowledge latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      lat_cnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      lat_cnt <= 0;
      ack_cnt <= ack_cnt + 1;
    end else if (mem_req) begin
      if (lat_cnt == LAT - 1) mem_ack <= 1'b1;
      else                    lat_cnt <= lat_cnt + 1;
    end
  end

  // monitor: compare each new command against the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_req && !prev_req) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected command: actual we=%0b bank=%0d addr=%0d expected none",
                 mem_we, mem_bank, mem_addr);
      end else begin
        cmd_t e;
        e = exp_q.pop_front();
        if (mem_we !== e.we || mem_bank !== e.bank || mem_addr !== e.addr) begin
          n_fail++;
          $display("FAIL %s: actual we=%0b bank=%0d addr=%0d expected we=%0b bank=%0d addr=%0d",
                   e.tag, mem_we, mem_bank, mem_addr, e.we, e.bank, e.addr);
        end
      end
    end
    prev_req <= mem_req;
  end

  task automatic push(input logic we, input logic [1:0] bank, input int addr, input string tag);
    cmd_t c;
    c.we = we; c.bank = bank; c.addr = ADDR_W'(addr); c.tag = tag;
    exp_q.push_back(c);
  endtask

  task automatic wait_acks(input int n, input bit stop);
    int target;
    target = ack_cnt + n;
    while (ack_cnt < target) @(negedge clk);
    if (stop) begin
      wr_fifo_level = '0;
      rd_fifo_space = '0;
    end
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mem_req) seen = 1'b1;
    end
    n_checks++;
    if (seen) begin
      n_fail++;
      $display("FAIL %s: actual request raised expected none", tag);
    end
  endtask

  task automatic pulse_wdone();
    @(negedge clk) wr_frame_done = 1'b1;
    @(negedge clk) wr_frame_done = 1'b0;
  endtask

  task automatic pulse_rdone();
    @(negedge clk) rd_frame_done = 1'b1;
    @(negedge clk) rd_frame_done = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    wr_fifo_level = '0; rd_fifo_space = '0;
    wr_frame_done = 1'b0; rd_frame_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    quiet(4, "R1 reset idle");

    // R3: no read before a frame has completed
    rd_fifo_space = LVL_W'(BURST);
    quiet(20, "R3 no read before first frame");
    rd_fifo_space = '0;

    // R1, R5: bank 0, stepping and wrap
    push(1, 0, 0,  "R1 first write");
    push(1, 0, 4,  "R5 step");
    push(1, 0, 8,  "R5 step");
    push(1, 0, 12, "R5 step");
    push(1, 0, 0,  "R5 wrap");
    wr_fifo_level = LVL_W'(8);
    wait_acks(5, 1);

    // R8, R6: frame-done during a burst is deferred
    push(1, 0, 4, "R8 in-flight burst keeps bank");
    push(1, 3, 0, "R6 switch to bank 3");
    wr_fifo_level = LVL_W'(BURST);
    while (!mem_req) @(negedge clk);
    wr_frame_done = 1'b1;
    @(negedge clk) wr_frame_done = 1'b0;
    wait_acks(2, 1);

    // R7: read the completed bank
    push(0, 0, 0, "R7 read completed bank");
    push(0, 0, 4, "R5 read step");
    rd_fifo_space = LVL_W'(BURST);
    wait_acks(2, 1);

    // R4: write wins over read
    push(1, 3, 4, "R4 write priority");
    wr_fifo_level = LVL_W'(BURST);
    rd_fifo_space = LVL_W'(BURST);
    wait_acks(1, 0);
    wr_fifo_level = '0;
    push(0, 0, 8, "R4 read after write");
    wait_acks(1, 1);

    // R9: read restart keeps bank
    pulse_rdone();
    push(0, 0, 0, "R9 read restart");
    rd_fifo_space = LVL_W'(BURST);
    wait_acks(1, 1);

    // R6, R7: idle frame switch, both pointers move
    pulse_wdone();
    push(0, 3, 0,  "R7 read follows completed bank");
    push(0, 3, 4,  "R5 read step");
    push(0, 3, 8,  "R5 read step");
    push(0, 3, 12, "R5 read step");
    push(0, 3, 0,  "R5 read wrap");
    rd_fifo_space = LVL_W'(BURST);
    wait_acks(5, 1);
    push(1, 0, 0, "R6 back to bank 0");
    wr_fifo_level = LVL_W'(BURST);
    wait_acks(1, 1);

    // R2, R3: one below threshold
    wr_fifo_level = LVL_W'(BURST - 1);
    rd_fifo_space = LVL_W'(BURST - 1);
    quiet(20, "R2 R3 below threshold");
    push(1, 0, 4, "R2 exact threshold");
    wr_fifo_level = LVL_W'(BURST);
    wait_acks(1, 1);
    quiet(6, "R10 no extra burst");

    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R10 missing commands: actual %0d left expected 0", exp_q.size());
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule